// File: doc/BRIEF.md
# Converter Interrupt Flag Controller

This block turns end-of-conversion (EOC) events from a data converter into nine interrupt lines for a processor. Each line watches one of up to 32 EOC inputs, chosen by a 5-bit source field. When the selected input is high on a clock edge and the line is enabled, the line sends out a single-cycle interrupt pulse on the next cycle. It also sets a sticky flag that software can read.

Each line runs in one of two modes. In continuous mode every selected event fires a pulse. In the other mode the line is held off after its first pulse. Any event that arrives while the flag is still pending is recorded in an overflow flag. Pulses come back only after software has cleared both the flag and the overflow flag. Software reaches the flags, their clear registers and the per-line configuration through a simple register port: a write strobe, a 4-bit address, 16-bit write data, and read data that follows the address combinationally.

Top module: `cvt_irq_flag_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and no interrupt output is high.
- R2: When a line is enabled and its selected EOC input is high at a clock edge, that line's interrupt output is high for one cycle right after that edge, and its flag is set in the same cycle. Line n (n = 1..9) uses bit n-1 of the interrupt output and of every per-line register field.
- R3: Address 0 returns the nine flags in bits 8..0, with bits 15..9 at zero. Writes to address 0 change nothing.
- R4: Writing 1s to address 1 clears the matching flags, and bits written as 0 leave their flags alone. Address 1 and address 3 always read zero.
- R5: An event on a line whose flag is already set sets that line's overflow flag. The overflow flags read at address 2 in bits 8..0, and writing 1s to address 3 clears them.
- R6: With continuous mode off, a line fires no pulse while its flag or its overflow flag is set. Clearing only the flag does not bring pulses back if the overflow flag is still set.
- R7: With continuous mode on, every selected event fires a pulse, including events on back-to-back cycles, whatever the flag holds. The overflow flag is still recorded in this mode.
- R8: A line whose enable bit is 0 makes no pulse and sets neither its flag nor its overflow flag.
- R9: If a flag-clear write and a selected event for the same line land on the same cycle, the flag stays set.
- R10: Only the EOC input picked by a line's source field can trigger that line.
- R11: Address 4 holds the enable bits and address 5 the continuous-mode bits, both in bits 8..0. Addresses 6 to 14 hold the 5-bit source field (bits 4..0) of lines 1 to 9. All of these read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoc_i | input | 32 | End-of-conversion event inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| irq_o | output | 9 | Single-cycle interrupt pulses, one per line |

## Verification
The main test walks one non-continuous line through a scripted run of events and clears. This sequence separates three cases: a blocked line that only records overflow, a line that is still blocked because only its flag was cleared, and a line that fires again once both flags are gone. It also includes a clear that lands together with an event. A second line gets events on back-to-back cycles in continuous mode, which shows that pulses keep firing while the overflow flag still sets. Events on an unselected input and on a disabled line show that source selection and the enable truly gate the line. Writes to the read-only flag address show that nothing changes.

// File: rtl/cvt_irq_pkg.sv
package cvt_irq_pkg;

    localparam int LINES     = 9;
    localparam int SRC_COUNT = 32;
    localparam int SEL_W     = $clog2(SRC_COUNT);
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] A_FLAG     = 4'd0;
    localparam logic [ADDR_W-1:0] A_FLAG_CLR = 4'd1;
    localparam logic [ADDR_W-1:0] A_OVF      = 4'd2;
    localparam logic [ADDR_W-1:0] A_OVF_CLR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 4'd4;
    localparam logic [ADDR_W-1:0] A_CONT     = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 4'd6;

    typedef struct packed {
        logic             en;
        logic             cont;
        logic [SEL_W-1:0] sel;
    } line_cfg_t;

    function automatic logic [DATA_W-1:0] widen_lines(input logic [LINES-1:0] v);
        return {{(DATA_W-LINES){1'b0}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] widen_sel(input logic [SEL_W-1:0] v);
        return {{(DATA_W-SEL_W){1'b0}}, v};
    endfunction

    function automatic logic [ADDR_W-1:0] sel_addr(input int idx);
        return A_SEL_BASE + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/cvt_irq_cfg.sv
module cvt_irq_cfg
    import cvt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output line_cfg_t         cfg_o [LINES],
    output logic [LINES-1:0]  flag_clr_o,
    output logic [LINES-1:0]  ovf_clr_o
);

    line_cfg_t cfg_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wr_i) begin
                if (addr_i == A_ENABLE) cfg_q[i].en   <= wdata_i[i];
                if (addr_i == A_CONT)   cfg_q[i].cont <= wdata_i[i];
                if (addr_i == sel_addr(i)) cfg_q[i].sel <= wdata_i[SEL_W-1:0];
            end
        end
        assign cfg_o[i] = cfg_q[i];
    end

    assign flag_clr_o = (wr_i && addr_i == A_FLAG_CLR) ? wdata_i[LINES-1:0] : '0;
    assign ovf_clr_o  = (wr_i && addr_i == A_OVF_CLR)  ? wdata_i[LINES-1:0] : '0;

endmodule

// File: rtl/cvt_irq_line.sv
module cvt_irq_line
    import cvt_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  line_cfg_t            cfg_i,
    input  logic [SRC_COUNT-1:0] eoc_i,
    input  logic                 flag_clr_i,
    input  logic                 ovf_clr_i,
    output logic                 irq_o,
    output logic                 flag_o,
    output logic                 ovf_o
);

    logic flag_q, ovf_q, irq_q;
    logic evt, held, fire;

    assign evt  = cfg_i.en & eoc_i[cfg_i.sel];
    assign held = ~cfg_i.cont & (flag_q | ovf_q);
    assign fire = evt & ~held;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q  <= fire;
            flag_q <= fire | (flag_q & ~(flag_clr_i & ~evt));
            ovf_q  <= (evt & flag_q) | (ovf_q & ~ovf_clr_i);
        end
    end

    assign irq_o  = irq_q;
    assign flag_o = flag_q;
    assign ovf_o  = ovf_q;

    assert_irq_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> flag_q);
    assert_ovf_on_pending_R5: assert property (@(posedge clk) disable iff (rst)
        evt && flag_q |=> ovf_q);
    assert_held_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q && !cfg_i.cont |=> !irq_q);
    assert_cont_fires_R7: assert property (@(posedge clk) disable iff (rst)
        evt && cfg_i.cont |=> irq_q);
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.en |=> !irq_q);
    assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        evt && flag_q && flag_clr_i |=> flag_q);

endmodule

// File: rtl/cvt_irq_flag_ctrl.sv
module cvt_irq_flag_ctrl
    import cvt_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_COUNT-1:0] eoc_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic [LINES-1:0]     irq_o
);

    line_cfg_t        cfg [LINES];
    logic [LINES-1:0] flag_clr, ovf_clr, flags, ovfs;
    logic [LINES-1:0] en_bits, cont_bits;

    cvt_irq_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .cfg_o      (cfg),
        .flag_clr_o (flag_clr),
        .ovf_clr_o  (ovf_clr)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        cvt_irq_line u_line (
            .clk        (clk),
            .rst        (rst),
            .cfg_i      (cfg[i]),
            .eoc_i      (eoc_i),
            .flag_clr_i (flag_clr[i]),
            .ovf_clr_i  (ovf_clr[i]),
            .irq_o      (irq_o[i]),
            .flag_o     (flags[i]),
            .ovf_o      (ovfs[i])
        );
        assign en_bits[i]   = cfg[i].en;
        assign cont_bits[i] = cfg[i].cont;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_FLAG:   reg_rdata_o = widen_lines(flags);
            A_OVF:    reg_rdata_o = widen_lines(ovfs);
            A_ENABLE: reg_rdata_o = widen_lines(en_bits);
            A_CONT:   reg_rdata_o = widen_lines(cont_bits);
            default: begin
                for (int i = 0; i < LINES; i++) begin
                    if (reg_addr_i == sel_addr(i)) reg_rdata_o = widen_sel(cfg[i].sel);
                end
            end
        endcase
    end

    assert_clr_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == A_FLAG_CLR || reg_addr_i == A_OVF_CLR) |-> reg_rdata_o == '0);
    assert_flag_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i && reg_addr_i == A_FLAG && eoc_i == '0 |=> $stable(flags));

endmodule

// File: tb/cvt_irq_flag_ctrl_tb.sv
module cvt_irq_flag_ctrl_tb;
    import cvt_irq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [SRC_COUNT-1:0] eoc = '0;
    logic                 wr = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [DATA_W-1:0]    wdata = '0;
    logic [DATA_W-1:0]    rdata;
    logic [LINES-1:0]     irq;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cvt_irq_flag_ctrl u_dut (
        .clk(clk), .rst(rst), .eoc_i(eoc), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // Vector: {event on input 3, flag-clear line 1, ovf-clear line 1, exp irq, exp flag, exp ovf}
    localparam logic [5:0] VEC [11] = '{
        6'b100_110,   // R2 first event fires
        6'b000_010,   // R2 pulse lasts one cycle
        6'b100_011,   // R5/R6 held, overflow recorded
        6'b010_001,   // R4 clear flag only
        6'b100_001,   // R6 still held by overflow
        6'b001_000,   // R5 clear overflow
        6'b100_110,   // R6 fires again
        6'b110_011,   // R9 clear with event, flag stays
        6'b010_001,   // R4 flag cleared
        6'b001_000,   // R5 overflow cleared
        6'b100_110    // R2 fires again
    };

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wreg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #2;
        wr = 1'b0;
    endtask

    task automatic pulse_eoc(input logic [SRC_COUNT-1:0] e);
        @(negedge clk);
        eoc = e;
        @(posedge clk);
        #2;
        eoc = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 irq after reset", 16'(irq), 16'h0);
        for (int a = 0; a < 15; a++) begin
            rd(ADDR_W'(a), d);
            chk("R1 register after reset", d, 16'h0);
        end

        wreg(A_SEL_BASE, 16'd3);
        wreg(A_ENABLE, 16'h0001);
        wreg(A_CONT, 16'h0000);

        for (int i = 0; i < 11; i++) begin
            logic [5:0] v;
            v = VEC[i];
            @(negedge clk);
            eoc = v[5] ? 32'h8 : 32'h0;
            wr = v[4] | v[3];
            addr = v[4] ? A_FLAG_CLR : A_OVF_CLR;
            wdata = 16'h0001;
            @(posedge clk);
            #2;
            eoc = '0; wr = 1'b0;
            chk("R2/R6 table irq", 16'(irq), {15'h0, v[2]});
            rd(A_FLAG, d);
            chk("R3/R4/R9 table flag", d, {15'h0, v[1]});
            rd(A_OVF, d);
            chk("R5/R6 table ovf", d, {15'h0, v[0]});
        end

        // R3: write to flag address ignored; flag of line 1 still set
        wreg(A_FLAG, 16'hFFFF);
        rd(A_FLAG, d);
        chk("R3 flag write ignored", d, 16'h0001);
        rd(A_FLAG_CLR, d);
        chk("R4 clear addr reads zero", d, 16'h0);
        rd(A_OVF_CLR, d);
        chk("R4 ovf clear addr reads zero", d, 16'h0);
        wreg(A_FLAG_CLR, 16'h0000);
        rd(A_FLAG, d);
        chk("R4 zero bits keep flag", d, 16'h0001);
        wreg(A_FLAG_CLR, 16'h0001);
        rd(A_FLAG, d);
        chk("R4 flag cleared", d, 16'h0);

        // R10: unselected input has no effect
        pulse_eoc(32'h20);
        chk("R10 unselected irq", 16'(irq), 16'h0);
        rd(A_FLAG, d);
        chk("R10 unselected flag", d, 16'h0);

        // R7: line 2 continuous, source 7, back-to-back events
        wreg(sel_addr(1), 16'd7);
        wreg(A_ENABLE, 16'h0003);
        wreg(A_CONT, 16'h0002);
        rd(sel_addr(1), d);
        chk("R11 sel readback", d, 16'd7);
        rd(A_SEL_BASE, d);
        chk("R11 sel line1 readback", d, 16'd3);
        rd(A_ENABLE, d);
        chk("R11 enable readback", d, 16'h0003);
        rd(A_CONT, d);
        chk("R11 cont readback", d, 16'h0002);
        @(negedge clk);
        eoc = 32'h80;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #2;
            chk("R7 back-to-back irq", 16'(irq), 16'h0002);
            rd(A_OVF, d);
            chk("R7 ovf in continuous", d, (c == 0) ? 16'h0 : 16'h0002);
        end
        eoc = '0;
        @(posedge clk);
        #2;
        chk("R7 idle irq", 16'(irq), 16'h0);
        rd(A_FLAG, d);
        chk("R7 flag set", d, 16'h0002);

        // R8: disable line 1, event on its source
        wreg(A_ENABLE, 16'h0002);
        pulse_eoc(32'h8);
        chk("R8 disabled irq", 16'(irq), 16'h0);
        rd(A_FLAG, d);
        chk("R8 disabled flag", d, 16'h0002);
        rd(A_OVF, d);
        chk("R8 disabled ovf", d, 16'h0002);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule